// File: doc/BRIEF.md
# Streaming Depuncturer

This block undoes puncturing on a rate-1/2 convolutional code stream before it reaches the decoder. Samples arrive one per valid cycle. They can be hard bits, signed soft values or unsigned soft values. The block walks a puncture pattern two entries at a time and produces one output pair for each pattern pair. A position marked 1 takes the next arriving sample. A position marked 0 is filled with a neutral value that carries no information, and the matching erasure bit is raised. Because of this, the output rate depends on the pattern.

The pattern is either a build-time parameter or a runtime input. It is latched only at an alignment point. In continuous mode that point is a sync pulse that comes with a valid sample. In frame mode it is a frame-start flag that comes with a valid sample. Leading all-zero pairs are dropped, so shorter patterns can be zero-padded up to one common length. In frame mode the start and end markers leave the block on the output pairs they belong to. A pattern pair of 00 is illegal. It raises an error flag without stalling the stream.

Top module: `depunc_stream`

## Requirements
- R1: Pattern bit k of `pat_i` is pattern entry k. Pattern pair p is made of entries 2p and 2p+1, and entry 2p maps to output element 0 (`data0_o`). Positions holding 1 are filled with input samples in arrival order.
- R2: A pair of 11 takes two valid samples and produces its output only on the second. A pair of 01 or 10 takes one valid sample and produces its output in the same step.
- R3: `erase_o` bit k is 1 exactly when output element k holds the neutral value, that is, the bitwise inverse of the pattern pair.
- R4: The neutral value is 2^(W-1) for unsigned soft samples (128 at W=8). It is 0 for signed soft samples and for hard 1-bit samples.
- R5: Cycles with `valid_i` low change nothing. They advance no pointer, complete no pair and load no pattern.
- R6: On a valid sample at a 00 pair, the block outputs both elements neutral, sets `erase_o`=11 and raises `err_o` with that pair. The sample is dropped and the pointer moves on.
- R7: Pattern pairs ahead of the first pair that contains a 1 are skipped. After the last pair, the walk goes back to the first kept pair with no idle step.
- R8: An output pair appears 7 cycles after the cycle of the sample that completes it in continuous mode, and 6 cycles after in frame mode.
- R9: Continuous mode: `sync_i` together with `valid_i` latches `pat_i` and restarts at the first kept pair. Any half-built 11 pair is discarded, and that sample is treated under the new pattern. Changes on `pat_i` at any other time have no effect.
- R10: Frame mode: `start_i` together with `valid_i` latches the pattern and restarts the walk. `start_o` marks the first output pair after that point, and `end_o` marks the pair completed by the sample that carries `end_i`. `sync_i` is ignored. In continuous mode `start_o` and `end_o` stay low.
- R11: While reset is held, and after it until the first completed pair, `valid_o`, `err_o`, `start_o` and `end_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | W | Input sample |
| valid_i | input | 1 | Input sample is valid |
| sync_i | input | 1 | Pattern alignment pulse (continuous mode) |
| start_i | input | 1 | Frame start (frame mode) |
| end_i | input | 1 | Frame end (frame mode) |
| pat_i | input | PAT_LEN | Runtime puncture pattern, bit k = entry k |
| data0_o | output | W | Output element 0 |
| data1_o | output | W | Output element 1 |
| valid_o | output | 1 | Output pair is valid |
| erase_o | output | 2 | Per-element neutral marker |
| start_o | output | 1 | First pair of frame |
| end_o | output | 1 | Last pair of frame |
| err_o | output | 1 | Illegal 00 pattern pair seen |

## Verification
The assertions assume that reset holds `valid_i` low. They also assume that a frame's end sample always completes a pair, so no frame ends halfway through an 11 pair. The directed stimulus follows both rules: it releases reset with all inputs idle, and it sizes every frame to a whole number of pattern pairs. Patterns that contain a 00 pair after the first kept pair are sent on purpose, to exercise the error path.

// File: rtl/depunc_pkg.sv
package depunc_pkg;

  typedef enum logic [1:0] {
    KIND_HARD,
    KIND_SIGNED,
    KIND_UNSIGNED
  } sample_kind_e;

  // index of the lowest pattern pair that holds a 1; 0 if none
  function automatic int first_pair_idx(input logic [31:0] pat, input int npair);
    int r;
    r = 0;
    for (int i = npair - 1; i >= 0; i--) begin
      if (pat[2*i +: 2] != 2'b00) r = i;
    end
    return r;
  endfunction

  function automatic logic [15:0] neutral_val(input sample_kind_e kind, input int w);
    logic [15:0] r;
    r = '0;
    if (kind == KIND_UNSIGNED) r[w-1] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/depunc_pat_sel.sv
module depunc_pat_sel
  import depunc_pkg::*;
#(
  parameter int                   PAT_LEN       = 10,
  parameter bit                   PAT_FROM_PORT = 1'b1,
  parameter logic [PAT_LEN-1:0]   PAT_DEFAULT   = 10'h1B0,
  localparam int                  NPAIR         = PAT_LEN / 2,
  localparam int                  PW            = $clog2(NPAIR)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [PAT_LEN-1:0] pat_i,
  output logic [PAT_LEN-1:0] pat_o,
  output logic [PW-1:0]      first_o
);

  localparam logic [PW-1:0] FIRST_RST = PW'(first_pair_idx(32'(PAT_DEFAULT), NPAIR));

  logic [PAT_LEN-1:0] src_pat;
  logic [PW-1:0]      src_first;
  logic [PAT_LEN-1:0] pat_q;
  logic [PW-1:0]      first_q;

  generate
    if (PAT_FROM_PORT) begin : g_port
      assign src_pat   = pat_i;
      assign src_first = PW'(first_pair_idx(32'(pat_i), NPAIR));
    end else begin : g_fixed
      logic unused_pat;
      assign unused_pat = ^pat_i;
      assign src_pat    = PAT_DEFAULT;
      assign src_first  = FIRST_RST;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q   <= PAT_DEFAULT;
      first_q <= FIRST_RST;
    end else if (load_i) begin
      pat_q   <= src_pat;
      first_q <= src_first;
    end
  end

  // new pattern takes effect on the sample that carries the load
  assign pat_o   = load_i ? src_pat   : pat_q;
  assign first_o = load_i ? src_first : first_q;

  AST_PAT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(pat_q) && $stable(first_q)); // R9

endmodule

// File: rtl/depunc_pair_asm.sv
module depunc_pair_asm #(
  parameter int         W          = 8,
  parameter int         PAT_LEN    = 10,
  parameter bit         FRAME_MODE = 1'b0,
  parameter logic [W-1:0] NEUTRAL  = '0,
  parameter int         FIRST_RST  = 0,
  localparam int        NPAIR      = PAT_LEN / 2,
  localparam int        PW         = $clog2(NPAIR)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [W-1:0]       data_i,
  input  logic               load_i,
  input  logic               end_i,
  input  logic [PAT_LEN-1:0] pat_i,
  input  logic [PW-1:0]      first_i,
  output logic               v_o,
  output logic [W-1:0]       d0_o,
  output logic [W-1:0]       d1_o,
  output logic [1:0]         erase_o,
  output logic               err_o,
  output logic               start_o,
  output logic               end_o
);

  localparam logic [PW-1:0] LAST_PTR = PW'(NPAIR - 1);

  logic [PW-1:0] ptr_q, ptr_d, cur_ptr;
  logic          half_q, half_d, cur_half;
  logic [W-1:0]  hold_q, hold_d;
  logic          spend_q, spend_d, start_now;
  logic [1:0]    pb;
  logic          fire;
  logic [W-1:0]  nd0, nd1;

  always_comb begin
    cur_ptr  = load_i ? first_i : ptr_q;
    cur_half = load_i ? 1'b0 : half_q;
    pb       = pat_i[{cur_ptr, 1'b0} +: 2];
    fire     = 1'b0;
    nd0      = NEUTRAL;
    nd1      = NEUTRAL;
    half_d   = cur_half;
    hold_d   = hold_q;
    if (valid_i) begin
      case (pb)
        2'b11: begin
          if (!cur_half) begin
            hold_d = data_i;
            half_d = 1'b1;
          end else begin
            fire   = 1'b1;
            nd0    = hold_q;
            nd1    = data_i;
            half_d = 1'b0;
          end
        end
        2'b01:   begin fire = 1'b1; nd0 = data_i; end
        2'b10:   begin fire = 1'b1; nd1 = data_i; end
        default: fire = 1'b1;
      endcase
    end
    ptr_d = cur_ptr;
    if (fire) ptr_d = (cur_ptr == LAST_PTR) ? first_i : cur_ptr + PW'(1);
    start_now = (FRAME_MODE && load_i) || spend_q;
    spend_d   = fire ? 1'b0 : start_now;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= PW'(FIRST_RST);
      half_q  <= 1'b0;
      hold_q  <= '0;
      spend_q <= 1'b0;
      v_o     <= 1'b0;
      d0_o    <= '0;
      d1_o    <= '0;
      erase_o <= 2'b00;
      err_o   <= 1'b0;
      start_o <= 1'b0;
      end_o   <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      half_q  <= half_d;
      hold_q  <= hold_d;
      spend_q <= spend_d;
      v_o     <= fire;
      d0_o    <= nd0;
      d1_o    <= nd1;
      erase_o <= fire ? ~pb : 2'b00;
      err_o   <= fire && (pb == 2'b00);
      start_o <= fire && start_now;
      end_o   <= FRAME_MODE && fire && end_i;
    end
  end

  AST_FIRST_HALF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !load_i && !half_q && pb == 2'b11) |=> !v_o); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(ptr_q) && $stable(half_q) && !v_o); // R5

endmodule

// File: rtl/depunc_delay.sv
module depunc_delay #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      logic [WIDTH-1:0] q;
      if (g == 0) begin : g_head
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) q <= '0;
          else         q <= d_i;
        end
      end else begin : g_tail
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) q <= '0;
          else         q <= g_stage[g-1].q;
        end
      end
    end
  endgenerate

  assign q_o = g_stage[DEPTH-1].q;

endmodule

// File: rtl/depunc_stream.sv
module depunc_stream
  import depunc_pkg::*;
#(
  parameter int                 W             = 8,
  parameter sample_kind_e       KIND          = KIND_UNSIGNED,
  parameter int                 PAT_LEN       = 10,
  parameter bit                 PAT_FROM_PORT = 1'b1,
  parameter bit                 FRAME_MODE    = 1'b0,
  parameter logic [PAT_LEN-1:0] PAT_DEFAULT   = 10'h1B0,
  localparam int                NPAIR         = PAT_LEN / 2,
  localparam int                PW            = $clog2(NPAIR),
  localparam int                LAT           = FRAME_MODE ? 6 : 7,
  localparam int                PL            = 2 * W + 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [W-1:0]       data_i,
  input  logic               valid_i,
  input  logic               sync_i,
  input  logic               start_i,
  input  logic               end_i,
  input  logic [PAT_LEN-1:0] pat_i,
  output logic [W-1:0]       data0_o,
  output logic [W-1:0]       data1_o,
  output logic               valid_o,
  output logic [1:0]         erase_o,
  output logic               start_o,
  output logic               end_o,
  output logic               err_o
);

  localparam logic [W-1:0] NEUTRAL   = W'(neutral_val(KIND, W));
  localparam int           FIRST_RST = first_pair_idx(32'(PAT_DEFAULT), NPAIR);

  logic               load;
  logic [PAT_LEN-1:0] eff_pat;
  logic [PW-1:0]      eff_first;
  logic               a_v, a_err, a_st, a_en;
  logic [W-1:0]       a_d0, a_d1;
  logic [1:0]         a_er;
  logic [PL-1:0]      pay_in, pay_out;

  assign load = valid_i && (FRAME_MODE ? start_i : sync_i);

  depunc_pat_sel #(
    .PAT_LEN      (PAT_LEN),
    .PAT_FROM_PORT(PAT_FROM_PORT),
    .PAT_DEFAULT  (PAT_DEFAULT)
  ) pat_sel_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .pat_i  (pat_i),
    .pat_o  (eff_pat),
    .first_o(eff_first)
  );

  depunc_pair_asm #(
    .W         (W),
    .PAT_LEN   (PAT_LEN),
    .FRAME_MODE(FRAME_MODE),
    .NEUTRAL   (NEUTRAL),
    .FIRST_RST (FIRST_RST)
  ) pair_asm_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (data_i),
    .load_i (load),
    .end_i  (end_i),
    .pat_i  (eff_pat),
    .first_i(eff_first),
    .v_o    (a_v),
    .d0_o   (a_d0),
    .d1_o   (a_d1),
    .erase_o(a_er),
    .err_o  (a_err),
    .start_o(a_st),
    .end_o  (a_en)
  );

  assign pay_in = {a_st, a_en, a_err, a_er, a_d1, a_d0, a_v};

  depunc_delay #(
    .WIDTH(PL),
    .DEPTH(LAT - 1)
  ) delay_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pay_in),
    .q_o   (pay_out)
  );

  assign {start_o, end_o, err_o, erase_o, data1_o, data0_o, valid_o} = pay_out;

  AST_NEUTRAL_EL0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && erase_o[0]) |-> data0_o == NEUTRAL); // R4
  AST_NEUTRAL_EL1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && erase_o[1]) |-> data1_o == NEUTRAL); // R4
  AST_ERR_FULL_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (valid_o && erase_o == 2'b11)); // R6
  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, LAT)); // R8
  AST_FLAGS_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || end_o) |-> (FRAME_MODE && valid_o)); // R10
  AST_QUIET_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!err_o && !start_o && !end_o && erase_o == 2'b00)); // R11

endmodule

// File: tb/depunc_stream_tb_top.sv
module depunc_stream_tb_top;
  import depunc_pkg::*;

  localparam int          CLK_PERIOD = 10;
  localparam int          LAT_A      = 7;
  localparam int          LAT_B      = 6;
  localparam logic [9:0]  PAT_A0     = 10'h1B0; // 0 0 0 0 1 1 0 1 1 0
  localparam logic [9:0]  PAT_A1     = 10'h19B; // 1 1 0 1 1 0 0 1 1 0
  localparam logic [9:0]  PAT_AE     = 10'h34C; // 0 0 1 1 0 0 1 0 1 1
  localparam logic [9:0]  PAT_B      = 10'h1C0; // 0 0 0 0 0 0 1 1 1 0
  localparam int          WDOG       = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = '0;
  logic       valid = 1'b0, sync = 1'b0, fstart = 1'b0, fend = 1'b0;
  logic [9:0] pat_in = PAT_A0;

  logic [7:0] a_d0, a_d1;
  logic       a_v, a_st, a_en, a_err;
  logic [1:0] a_er;
  logic [3:0] b_d0, b_d1;
  logic       b_v, b_st, b_en, b_err;
  logic [1:0] b_er;

  int  cyc = 0, n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  string cur_tag = "R11";

  typedef struct {
    logic [7:0] d0, d1;
    logic [1:0] er;
    logic       err, st, en;
    int         cyc;
    string      tag;
  } exp_t;

  exp_t       q0[$], q1[$];
  logic [9:0] mp[2];
  int         mptr[2];
  bit         mhalf[2];
  logic [7:0] mhold[2];
  bit         mspend;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  depunc_stream #(
    .W(8), .KIND(KIND_UNSIGNED), .PAT_LEN(10), .PAT_FROM_PORT(1'b1),
    .FRAME_MODE(1'b0), .PAT_DEFAULT(PAT_A0)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid),
    .sync_i(sync), .start_i(fstart), .end_i(fend), .pat_i(pat_in),
    .data0_o(a_d0), .data1_o(a_d1), .valid_o(a_v), .erase_o(a_er),
    .start_o(a_st), .end_o(a_en), .err_o(a_err)
  );

  depunc_stream #(
    .W(4), .KIND(KIND_SIGNED), .PAT_LEN(10), .PAT_FROM_PORT(1'b0),
    .FRAME_MODE(1'b1), .PAT_DEFAULT(PAT_B)
  ) dut_f_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data[3:0]), .valid_i(valid),
    .sync_i(sync), .start_i(fstart), .end_i(fend), .pat_i(pat_in),
    .data0_o(b_d0), .data1_o(b_d1), .valid_o(b_v), .erase_o(b_er),
    .start_o(b_st), .end_o(b_en), .err_o(b_err)
  );

  function automatic void check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s (cycle %0d)", tag, act, exp, cyc);
    end
  endfunction

  function automatic int first_of(input logic [9:0] p);
    int r = 0;
    for (int i = 4; i >= 0; i--) if (p[2*i +: 2] != 2'b00) r = i;
    return r;
  endfunction

  function automatic string fmt(input exp_t x);
    return $sformatf("d0=%0d d1=%0d er=%b err=%b st=%b en=%b cyc=%0d",
                     x.d0, x.d1, x.er, x.err, x.st, x.en, x.cyc);
  endfunction

  // reference: one valid step of the pattern walk, per requirements
  task automatic model_step(input int u, input bit v, input logic [7:0] d,
                            input bit s, input bit st, input bit en);
    logic [7:0] dv, nv, e0, e1;
    bit a, b, fire, ld;
    exp_t x;
    dv = (u == 0) ? d : {4'd0, d[3:0]};
    nv = (u == 0) ? 8'd128 : 8'd0;
    ld = v && ((u == 0) ? s : st);
    if (ld) begin
      mp[u]    = (u == 0) ? pat_in : PAT_B;
      mptr[u]  = first_of(mp[u]);
      mhalf[u] = 1'b0;
      if (u == 1) mspend = 1'b1;
    end
    if (!v) return;
    a = mp[u][2*mptr[u]];
    b = mp[u][2*mptr[u]+1];
    fire = 1'b0; e0 = nv; e1 = nv;
    if (a && b) begin
      if (!mhalf[u]) begin mhold[u] = dv; mhalf[u] = 1'b1; end
      else begin fire = 1'b1; e0 = mhold[u]; e1 = dv; mhalf[u] = 1'b0; end
    end else begin
      fire = 1'b1;
      if (a) e0 = dv;
      if (b) e1 = dv;
    end
    if (fire) begin
      x.d0 = e0; x.d1 = e1; x.er = {~b, ~a}; x.err = !a && !b;
      x.st = (u == 1) && mspend; x.en = (u == 1) && en;
      x.cyc = cyc + ((u == 0) ? LAT_A : LAT_B);
      x.tag = cur_tag;
      if (u == 1) mspend = 1'b0;
      if (u == 0) q0.push_back(x); else q1.push_back(x);
      mptr[u] = (mptr[u] == 4) ? first_of(mp[u]) : mptr[u] + 1;
    end
  endtask

  task automatic drive(input bit v, input logic [7:0] d, input bit s, input bit st, input bit en);
    @(negedge clk);
    valid = v; data = d; sync = s; fstart = st; fend = en;
    for (int u = 0; u < 2; u++) model_step(u, v, d, s, st, en);
  endtask

  task automatic drain();
    repeat (12) drive(1'b0, 8'hA5, 1'b0, 1'b0, 1'b0);
    check(q0.size() == 0, {cur_tag, " drain A"}, $sformatf("%0d pending", q0.size()), "0 pending");
    check(q1.size() == 0, {cur_tag, " drain B"}, $sformatf("%0d pending", q1.size()), "0 pending");
  endtask

  always @(negedge clk) begin
    exp_t x, g;
    if (rst_n && !done) begin
      if (a_v) begin
        g.d0 = a_d0; g.d1 = a_d1; g.er = a_er; g.err = a_err; g.st = a_st; g.en = a_en;
        g.cyc = cyc; g.tag = "";
        if (q0.size() == 0) check(1'b0, "R8 dut A", fmt(g), "no output");
        else begin
          x = q0.pop_front();
          check(g.d0 == x.d0 && g.d1 == x.d1 && g.er == x.er && g.err == x.err &&
                g.st == x.st && g.en == x.en && g.cyc == x.cyc,
                {x.tag, " dut A"}, fmt(g), fmt(x));
        end
      end
      if (b_v) begin
        g.d0 = {4'd0, b_d0}; g.d1 = {4'd0, b_d1}; g.er = b_er; g.err = b_err;
        g.st = b_st; g.en = b_en; g.cyc = cyc; g.tag = "";
        if (q1.size() == 0) check(1'b0, "R8 dut B", fmt(g), "no output");
        else begin
          x = q1.pop_front();
          check(g.d0 == x.d0 && g.d1 == x.d1 && g.er == x.er && g.err == x.err &&
                g.st == x.st && g.en == x.en && g.cyc == x.cyc,
                {x.tag, " dut B"}, fmt(g), fmt(x));
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      check(1'b0, "R8 watchdog", $sformatf("cycle %0d", cyc), $sformatf("< %0d", WDOG));
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic t_reset();
    cur_tag = "R11";
    repeat (4) @(negedge clk);
    check(!a_v && !a_err && !a_st && !a_en, "R11 dut A idle in reset",
          $sformatf("%b%b%b%b", a_v, a_err, a_st, a_en), "0000");
    check(!b_v && !b_err && !b_st && !b_en, "R11 dut B idle in reset",
          $sformatf("%b%b%b%b", b_v, b_err, b_st, b_en), "0000");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!a_v && !b_v, "R11 idle after reset", $sformatf("%b%b", a_v, b_v), "00");
  endtask

  task automatic t_basic();
    cur_tag = "R1 R2 R3 R4 R7 R8";
    pat_in = PAT_A0;
    drive(1'b1, 8'd11, 1'b1, 1'b0, 1'b0);
    for (int k = 1; k < 12; k++) drive(1'b1, 8'(k * 37 + 5), 1'b0, 1'b0, 1'b0);
    drain();
  endtask

  task automatic t_gaps();
    cur_tag = "R5";
    for (int k = 0; k < 10; k++) begin
      drive(1'b1, 8'(k * 19 + 3), 1'b0, 1'b0, 1'b0);
      for (int j = 0; j < k % 3; j++) begin
        pat_in = PAT_AE;
        drive(1'b0, 8'hEE, 1'b1, 1'b1, 1'b1); // ignored: no valid
        pat_in = PAT_A0;
      end
    end
    drain();
  endtask

  task automatic t_resync();
    cur_tag = "R9";
    pat_in = PAT_A0;
    drive(1'b1, 8'd200, 1'b1, 1'b0, 1'b0); // first half of a 11 pair
    pat_in = PAT_A1;
    drive(1'b1, 8'd17, 1'b1, 1'b0, 1'b0);  // restart, held sample dropped
    for (int k = 0; k < 10; k++) drive(1'b1, 8'(k * 23 + 40), 1'b0, 1'b0, 1'b0);
    pat_in = PAT_AE;                        // no sync: must be ignored
    for (int k = 0; k < 8; k++) drive(1'b1, 8'(k * 29 + 7), 1'b0, 1'b0, 1'b0);
    drain();
  endtask

  task automatic t_err();
    cur_tag = "R6 R7";
    pat_in = PAT_AE;
    drive(1'b1, 8'd90, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 14; k++) drive(1'b1, 8'(k * 41 + 1), 1'b0, 1'b0, 1'b0);
    drain();
  endtask

  task automatic t_frame();
    cur_tag = "R10";
    pat_in = PAT_A0;
    drive(1'b1, 8'h31, 1'b1, 1'b1, 1'b0);
    drive(1'b1, 8'h42, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 8'h53, 1'b1, 1'b0, 1'b0); // sync ignored by frame dut
    drive(1'b1, 8'h64, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 8'h75, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 8'h86, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 8'h97, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 8'hA8, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 8'hB9, 1'b0, 1'b0, 1'b1);
    drain();
  endtask

  initial begin
    mp[0] = PAT_A0; mptr[0] = first_of(PAT_A0); mhalf[0] = 1'b0; mhold[0] = '0;
    mp[1] = PAT_B;  mptr[1] = first_of(PAT_B);  mhalf[1] = 1'b0; mhold[1] = '0;
    mspend = 1'b0;
    t_reset();
    t_basic();
    t_gaps();
    t_resync();
    t_err();
    t_frame();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule